// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block owns the division ratios of a small set of derived clocks that all run from one source clock. Each derived clock is produced as a one-cycle clock-enable pulse, repeating once every N source cycles, where N is a power of two from 1 to 16. Software never changes a ratio directly. It first stages per-clock ratio codes in a ratio-staging register, then writes a keyed start word to the command register. The sequencer waits for a cycle where every divider sits at phase zero, applies the staged codes in that cycle, and clears the staging register.

One of the derived clocks is designated as the bus clock. If its code changes, the sequencer holds every clock enable low after the new ratios are applied. It waits for the PLL-locked input. It then runs a settle timer for a software-chosen interval before it lets the clocks resume. If the bus clock is not touched, the timer stays off and the clocks never stop. Software polls the command register: it reads 1 while a sequence is in progress and 0 once the sequence has finished.

Top module: `clkseq_top`

## Requirements
- R1: After reset, all four registers read 0, every divider runs at divide-by-1, and every `clk_en` bit is high.
- R2: A ratio code of 1, 2, 3, 4 or 5 sets that clock to divide-by 1, 2, 4, 8 or 16. A clock at divide-by-2^k raises its `clk_en` bit for one cycle out of every 2^k.
- R3: A sequence starts only on a write of exactly 0xCF000001 to the command register (address 0). A write of any other value leaves the command register reading 0 and leaves the ratios and the staged codes unchanged.
- R4: The command register reads 1 from the cycle after an accepted start until the sequence ends, and 0 afterwards. The ratio-staging register (address 1, clock d in bits 4d+3..4d) reads 0 once the codes have been applied.
- R5: A code of 0, or any code from 6 to 15, leaves that clock's current ratio unchanged.
- R6: New ratios take effect only in a cycle where every divider is at phase zero. After a change, all `clk_en` bits rise together once per period of the slowest clock.
- R7: If the bus clock code (field BUS_DOM) is not one of 1 to 5, the settle timer stays off and the timer-control bit (address 3, bit 0) reads 0 throughout the sequence.
- R8: If the bus clock code is one of 1 to 5, every `clk_en` bit is held low from the cycle after the codes are applied. The sequence ends exactly 2^N cycles after the first clock edge at which `pll_locked` is sampled high, and the clocks then resume.
- R9: The interval register (address 2, bit 0) accepts a write only when write-data bits 31..24 equal 0x55. Bit 0 set to 1 selects N = SHORT_LOG, and bit 0 set to 0 selects N = LONG_LOG.
- R10: A start word written while the timer-control bit is 1 is ignored. Software clears the bit by writing 0 to address 3 while no sequence is running.
- R11: A start word written while a sequence is in progress is ignored and does not change when that sequence ends.
- R12: While a sequence is in progress, writes to addresses 1, 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 2 | Register address: 0 command, 1 ratio staging, 2 interval, 3 timer control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pll_locked | input | 1 | PLL lock indication |
| clk_en | output | NUM_DOM | One enable per derived clock |

## Verification
The bench builds the block with three clocks (NUM_DOM=3), with clock 0 as the bus clock, SHORT_LOG=3 and LONG_LOG=5. These values make the settle intervals 8 and 32 cycles. As a result, both interval choices can be timed to the exact cycle many times within a short run, including several random bus-clock changes. With three clocks, the bench can mix ratio changes, undefined codes and bus-clock changes in one staged word. It then checks every resulting enable pattern against the period of the slowest clock.

// File: rtl/clkseq_pkg.sv
// Shared constants, types and ratio-code decoding for the clock ratio sequencer.
// Assumes ratio codes are 4 bits wide and the largest division is by 16.
package clkseq_pkg;

    localparam int FIELD_W = 4;
    localparam int MAX_LOG = 4;
    localparam int LOG_W   = 3;
    localparam int PHASE_W = MAX_LOG;

    localparam logic [31:0] START_WORD = 32'hCF00_0001;
    localparam logic [7:0]  IVL_KEY    = 8'h55;

    localparam logic [1:0] ADDR_CMD   = 2'd0;
    localparam logic [1:0] ADDR_STAGE = 2'd1;
    localparam logic [1:0] ADDR_IVL   = 2'd2;
    localparam logic [1:0] ADDR_TCTL  = 2'd3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ALIGN,
        SEQ_LOCK,
        SEQ_SETTLE
    } seq_state_t;

    // True when a code names a defined ratio (divide by 1, 2, 4, 8 or 16).
    function automatic logic code_valid(input logic [FIELD_W-1:0] code);
        return (code >= 4'd1) && (code <= 4'd5);
    endfunction

    // Converts a defined code to log2 of its division ratio.
    function automatic logic [LOG_W-1:0] code_log(input logic [FIELD_W-1:0] code);
        return LOG_W'(code - 4'd1);
    endfunction

endpackage

// File: rtl/clkseq_divider.sv
// One power-of-two clock-enable divider.
// Produces a one-cycle enable at phase zero of each period. A new ratio is taken
// when load and new_valid are both high. The controller asserts load only when
// every divider is at phase zero, so no shortened period can appear.
module clkseq_divider
    import clkseq_pkg::*;
#(
    parameter int RESET_LOG = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             new_valid,
    input  logic [LOG_W-1:0] new_log,
    input  logic             halt,
    output logic             clk_en,
    output logic             at_zero,
    output logic [LOG_W-1:0] cur_log
);

    localparam int SPAN_W = PHASE_W + 1;

    logic [LOG_W-1:0]   log_q;
    logic [PHASE_W-1:0] phase_q;
    logic [LOG_W-1:0]   eff_log;
    logic [SPAN_W-1:0]  span;
    logic [PHASE_W-1:0] wrap_at;

    // Selects the ratio that applies to the next phase step.
    always_comb begin
        eff_log = (load && new_valid) ? new_log : log_q;
        span    = SPAN_W'(1) << eff_log;
        wrap_at = PHASE_W'(span - 1'b1);
    end

    // Advances the phase counter and latches a new ratio on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q   <= LOG_W'(RESET_LOG);
            phase_q <= '0;
        end else begin
            if (load && new_valid) begin
                log_q <= new_log;
            end
            phase_q <= (phase_q >= wrap_at) ? '0 : phase_q + 1'b1;
        end
    end

    assign at_zero = (phase_q == '0);
    assign clk_en  = at_zero && !halt;
    assign cur_log = log_q;

endmodule

// File: rtl/clkseq_settle_timer.sv
// Settle-interval timer.
// While run is high it counts source cycles from zero. It pulses ovf on the
// cycle the count reaches 2^SHORT_LOG-1 or 2^LONG_LOG-1, whichever short_sel
// chooses. Dropping run clears the count. Assumes SHORT_LOG < LONG_LOG.
module clkseq_settle_timer #(
    parameter int SHORT_LOG = 8,
    parameter int LONG_LOG  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic short_sel,
    output logic ovf
);

    localparam int CNT_W = LONG_LOG;
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_LOG) - 64'd1);
    localparam logic [CNT_W-1:0] LONG_LAST  = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Chooses the terminal count from the interval selection.
    always_comb begin
        last = short_sel ? SHORT_LAST : LONG_LAST;
        ovf  = run && (cnt_q == last);
    end

    // Counts while running and restarts from zero on overflow or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || ovf) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clkseq_ctrl.sv
// Register file and sequence state machine.
// Holds the staged ratio codes, the interval selection and the timer-control
// bit. Accepts the keyed start word and steps through align, lock-wait and
// settle. Assumes NUM_DOM*4 <= 32 and that BUS_DOM names one of the clocks.
module clkseq_ctrl
    import clkseq_pkg::*;
#(
    parameter int NUM_DOM = 4,
    parameter int BUS_DOM = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [1:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic                       pll_locked,
    input  logic                       all_zero,
    input  logic                       tmr_ovf,
    output logic                       load,
    output logic [NUM_DOM*FIELD_W-1:0] divsel_q,
    output logic                       halt,
    output logic                       tmr_run,
    output logic                       short_sel,
    output logic                       busy,
    output logic                       tme,
    output logic                       bus_req
);

    localparam int STAGE_W = NUM_DOM * FIELD_W;

    seq_state_t         state_q;
    logic               wr_any;
    logic               wr_cmd;
    logic               wr_stage;
    logic               wr_ivl;
    logic               wr_tctl;
    logic               idle;
    logic               bus_code_ok;
    logic               start_ok;
    logic [FIELD_W-1:0] bus_code;

    // Decodes bus writes and the start condition.
    always_comb begin
        wr_any      = bus_sel && bus_wr;
        wr_cmd      = wr_any && (bus_addr == ADDR_CMD);
        wr_stage    = wr_any && (bus_addr == ADDR_STAGE);
        wr_ivl      = wr_any && (bus_addr == ADDR_IVL);
        wr_tctl     = wr_any && (bus_addr == ADDR_TCTL);
        idle        = (state_q == SEQ_IDLE);
        bus_code    = divsel_q[BUS_DOM*FIELD_W +: FIELD_W];
        bus_code_ok = code_valid(bus_code);
        start_ok    = wr_cmd && (bus_wdata == START_WORD) && idle && !tme;
    end

    // Steps the sequence: idle, align to phase zero, lock wait, settle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            bus_req <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_ok) begin
                        state_q <= SEQ_ALIGN;
                        bus_req <= bus_code_ok;
                    end
                end
                SEQ_ALIGN: begin
                    if (all_zero) begin
                        state_q <= bus_req ? SEQ_LOCK : SEQ_IDLE;
                    end
                end
                SEQ_LOCK: begin
                    if (pll_locked) begin
                        state_q <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (tmr_ovf) begin
                        state_q <= SEQ_IDLE;
                        bus_req <= 1'b0;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Holds the staged codes; they clear when applied and are frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divsel_q <= '0;
        end else if (load) begin
            divsel_q <= '0;
        end else if (wr_stage && idle) begin
            divsel_q <= bus_wdata[STAGE_W-1:0];
        end
    end

    // Holds the interval selection; a write needs the key byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_sel <= 1'b0;
        end else if (wr_ivl && idle && (bus_wdata[31:24] == IVL_KEY)) begin
            short_sel <= bus_wdata[0];
        end
    end

    // Timer-control bit: set at lock, cleared at overflow, software-written while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tme <= 1'b0;
        end else if ((state_q == SEQ_LOCK) && pll_locked) begin
            tme <= 1'b1;
        end else if (tmr_ovf) begin
            tme <= 1'b0;
        end else if (wr_tctl && idle) begin
            tme <= bus_wdata[0];
        end
    end

    assign load    = (state_q == SEQ_ALIGN) && all_zero;
    assign halt    = (state_q == SEQ_LOCK) || (state_q == SEQ_SETTLE);
    assign tmr_run = tme && (state_q == SEQ_SETTLE);
    assign busy    = !idle;

    // Read-data multiplexer.
    always_comb begin
        unique case (bus_addr)
            ADDR_CMD:   bus_rdata = {31'd0, busy};
            ADDR_STAGE: bus_rdata = 32'(divsel_q);
            ADDR_IVL:   bus_rdata = {31'd0, short_sel};
            default:    bus_rdata = {31'd0, tme};
        endcase
    end

endmodule

// File: rtl/clkseq_top.sv
// Clock ratio change sequencer top.
// Connects the register/sequence controller, one divider per derived clock,
// and the settle timer. All dividers reset to divide-by-1 so they start
// phase-aligned.
module clkseq_top
    import clkseq_pkg::*;
#(
    parameter int NUM_DOM   = 4,
    parameter int BUS_DOM   = 0,
    parameter int SHORT_LOG = 8,
    parameter int LONG_LOG  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               pll_locked,
    output logic [NUM_DOM-1:0] clk_en
);

    logic                       load;
    logic                       halt;
    logic                       tmr_run;
    logic                       tmr_ovf;
    logic                       short_sel;
    logic                       busy;
    logic                       tme;
    logic                       bus_req;
    logic                       all_zero;
    logic [NUM_DOM*FIELD_W-1:0] divsel_q;
    logic [NUM_DOM-1:0]         zero_vec;
    logic [NUM_DOM*LOG_W-1:0]   ratio_vec;

    assign all_zero = &zero_vec;

    clkseq_ctrl #(
        .NUM_DOM (NUM_DOM),
        .BUS_DOM (BUS_DOM)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_locked (pll_locked),
        .all_zero   (all_zero),
        .tmr_ovf    (tmr_ovf),
        .load       (load),
        .divsel_q   (divsel_q),
        .halt       (halt),
        .tmr_run    (tmr_run),
        .short_sel  (short_sel),
        .busy       (busy),
        .tme        (tme),
        .bus_req    (bus_req)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        logic [FIELD_W-1:0] code;
        assign code = divsel_q[d*FIELD_W +: FIELD_W];

        clkseq_divider #(
            .RESET_LOG (0)
        ) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .new_valid (code_valid(code)),
            .new_log   (code_log(code)),
            .halt      (halt),
            .clk_en    (clk_en[d]),
            .at_zero   (zero_vec[d]),
            .cur_log   (ratio_vec[d*LOG_W +: LOG_W])
        );
    end

    clkseq_settle_timer #(
        .SHORT_LOG (SHORT_LOG),
        .LONG_LOG  (LONG_LOG)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tmr_run),
        .short_sel (short_sel),
        .ovf       (tmr_ovf)
    );

endmodule

// File: rtl/clkseq_checker.sv
// Temporal checks for the clock ratio sequencer, bound into clkseq_top.
// Observes the bus ports and the signals that pass between the controller,
// the dividers and the timer.
module clkseq_checker
    import clkseq_pkg::*;
#(
    parameter int NUM_DOM = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [1:0]                 bus_addr,
    input logic [31:0]                bus_wdata,
    input logic [NUM_DOM-1:0]         clk_en,
    input logic                       busy,
    input logic                       load,
    input logic                       tmr_run,
    input logic                       tmr_ovf,
    input logic                       bus_req,
    input logic                       tme,
    input logic                       short_sel,
    input logic [NUM_DOM*FIELD_W-1:0] divsel_q,
    input logic [NUM_DOM-1:0]         zero_vec,
    input logic [NUM_DOM*LOG_W-1:0]   ratio_vec
);

    AST_START_KEY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_sel && bus_wr && bus_addr == ADDR_CMD && bus_wdata != START_WORD) |=> !busy); // R3

    AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (divsel_q == '0)); // R4

    AST_RATIO_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_vec) |-> $past(&zero_vec)); // R6

    AST_TIMER_OFF_NOBUS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_req) |-> !tme); // R7

    AST_TIMER_ONLY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> bus_req); // R7

    AST_SETTLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_run |-> (clk_en == '0)); // R8

    AST_OVF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> !busy); // R8

    AST_IVL_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == ADDR_IVL && bus_wdata[31:24] != IVL_KEY) |=> $stable(short_sel)); // R9

    AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load && bus_sel && bus_wr && bus_addr == ADDR_STAGE) |=> $stable(divsel_q)); // R12

endmodule

bind clkseq_top clkseq_checker #(
    .NUM_DOM (NUM_DOM)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .clk_en    (clk_en),
    .busy      (busy),
    .load      (load),
    .tmr_run   (tmr_run),
    .tmr_ovf   (tmr_ovf),
    .bus_req   (bus_req),
    .tme       (tme),
    .short_sel (short_sel),
    .divsel_q  (divsel_q),
    .zero_vec  (zero_vec),
    .ratio_vec (ratio_vec)
);

// File: tb/clkseq_top_test.sv
// Self-checking bench for clkseq_top: directed corner cases plus seeded random sequences.
module clkseq_top_test;

    localparam int NUM_DOM   = 3;
    localparam int BUS_DOM   = 0;
    localparam int SHORT_LOG = 3;
    localparam int LONG_LOG  = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [1:0]         bus_addr = 2'd0;
    logic [31:0]        bus_wdata = 32'd0;
    logic [31:0]        bus_rdata;
    logic               pll_locked = 1'b0;
    logic [NUM_DOM-1:0] clk_en;

    int checks = 0;
    int failures = 0;
    int cur_log [NUM_DOM];
    bit short_model = 1'b0;
    bit done = 1'b0;

    clkseq_top #(
        .NUM_DOM   (NUM_DOM),
        .BUS_DOM   (BUS_DOM),
        .SHORT_LOG (SHORT_LOG),
        .LONG_LOG  (LONG_LOG)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pll_locked (pll_locked),
        .clk_en     (clk_en)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic bit is_valid(input int code);
        return code >= 1 && code <= 5;
    endfunction

    function automatic void apply_model(input logic [31:0] stage);
        for (int d = 0; d < NUM_DOM; d++) begin
            int code = int'(stage[d*4 +: 4]);
            if (is_valid(code)) cur_log[d] = code - 1;
        end
    endfunction

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        rd(2'd0, v);
        while (v != 0 && n < 200) begin
            @(negedge clk);
            rd(2'd0, v);
            n++;
        end
        check(v == 0, req, v, 0);
    endtask

    // Finds the point where all enables rise together, then compares 32 cycles.
    task automatic check_pattern(input string req);
        int n = 0;
        int bad [NUM_DOM];
        while (clk_en != {NUM_DOM{1'b1}} && n < 40) begin
            @(negedge clk);
            n++;
        end
        check(clk_en == {NUM_DOM{1'b1}}, {req, " R6 aligned"}, clk_en, {NUM_DOM{1'b1}});
        for (int d = 0; d < NUM_DOM; d++) bad[d] = 0;
        for (int i = 0; i < 32; i++) begin
            for (int d = 0; d < NUM_DOM; d++) begin
                bit exp_en = ((i % (1 << cur_log[d])) == 0);
                if (clk_en[d] != exp_en) bad[d]++;
            end
            @(negedge clk);
        end
        for (int d = 0; d < NUM_DOM; d++) check(bad[d] == 0, {req, " R2 period"}, bad[d], 0);
    endtask

    // Runs a non-bus sequence and checks the result.
    task automatic run_plain(input logic [31:0] stage, input string req);
        logic [31:0] v;
        wr(2'd1, stage);
        wr(2'd0, 32'hCF00_0001);
        rd(2'd3, v);
        check(v == 0, "R7 timer off during plain change", v, 0);
        wait_idle({req, " R4 completes"});
        rd(2'd1, v);
        check(v == 0, "R4 staging cleared", v, 0);
        apply_model(stage);
        check_pattern(req);
    endtask

    // Runs a bus-clock sequence and times the settle interval exactly.
    task automatic run_bus(input logic [31:0] stage, input bit use_short, input bit poke);
        logic [31:0] v;
        int n = 0;
        int exp_n;
        int zero_bad = 0;
        wr(2'd2, use_short ? 32'h5500_0001 : 32'h5500_0000);
        short_model = use_short;
        rd(2'd2, v);
        check(v == 32'(use_short), "R9 keyed interval write", v, use_short);
        wr(2'd1, stage);
        wr(2'd0, 32'hCF00_0001);
        repeat (18) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (clk_en != 0) zero_bad++;
            @(negedge clk);
        end
        check(zero_bad == 0, "R8 enables held low before lock", zero_bad, 0);
        rd(2'd0, v);
        check(v == 1, "R4 busy while waiting for lock", v, 1);
        if (poke) begin
            wr(2'd1, 32'h0000_0333);
            wr(2'd2, 32'h5500_0001 ^ 32'(use_short));
            wr(2'd3, 32'h0000_0001);
            wr(2'd0, 32'hCF00_0001);
            rd(2'd1, v);
            check(v == 0, "R12 staging write ignored while busy", v, 0);
            rd(2'd2, v);
            check(v == 32'(use_short), "R12 interval write ignored while busy", v, use_short);
            rd(2'd3, v);
            check(v == 0, "R12 timer-control write ignored while busy", v, 0);
        end
        pll_locked = 1'b1;
        do begin
            @(negedge clk);
            n++;
            rd(2'd0, v);
        end while (v != 0 && n < 200);
        exp_n = (1 << (use_short ? SHORT_LOG : LONG_LOG)) + 1;
        check(n == exp_n, poke ? "R11 R8 settle length with extra start" : "R8 settle length", n, exp_n);
        pll_locked = 1'b0;
        apply_model(stage);
        check_pattern("R8 resume");
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] stage;
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        for (int d = 0; d < NUM_DOM; d++) cur_log[d] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check(v == 0, "R1 register reset", v, 0);
        end
        check(clk_en == {NUM_DOM{1'b1}}, "R1 enables high", clk_en, {NUM_DOM{1'b1}});

        // R2 R4 directed ratio change: clock 1 to /2, clock 2 to /16
        wr(2'd1, 32'h0000_0520);
        rd(2'd1, v);
        check(v == 32'h520, "R4 staging readback", v, 32'h520);
        run_plain(32'h0000_0520, "R2 directed");

        // R3 wrong start words
        wr(2'd1, 32'h0000_0040);
        wr(2'd0, 32'hCF00_0000);
        rd(2'd0, v);
        check(v == 0, "R3 near-miss start ignored", v, 0);
        wr(2'd0, 32'h4F00_0001);
        rd(2'd0, v);
        check(v == 0, "R3 wrong key ignored", v, 0);
        rd(2'd1, v);
        check(v == 32'h40, "R3 staging kept", v, 32'h40);
        check_pattern("R3 ratios unchanged");

        // R5 undefined and zero codes
        run_plain(32'h0000_00F0, "R5 undefined code");
        run_plain(32'h0000_0000, "R5 zero codes");

        // R10 start refused while timer-control bit set
        wr(2'd3, 32'h0000_0001);
        rd(2'd3, v);
        check(v == 1, "R10 timer-control set", v, 1);
        wr(2'd1, 32'h0000_0010);
        wr(2'd0, 32'hCF00_0001);
        rd(2'd0, v);
        check(v == 0, "R10 start refused", v, 0);
        rd(2'd1, v);
        check(v == 32'h10, "R10 staging kept", v, 32'h10);
        wr(2'd3, 32'h0000_0000);
        run_plain(32'h0000_0010, "R10 after clear");

        // R9 keyless interval write
        wr(2'd2, 32'h4400_0001);
        rd(2'd2, v);
        check(v == 0, "R9 keyless write ignored", v, 0);

        // R8 R11 R12 bus-clock changes with both intervals
        run_bus(32'h0000_0003, 1'b1, 1'b1);
        run_bus(32'h0000_0001, 1'b0, 1'b0);

        // Random mix
        for (int it = 0; it < 24; it++) begin
            int sel = int'($urandom % 4);
            stage = 32'($urandom) & 32'h0000_0FF0;
            if (($urandom % 2) == 1) stage[3:0] = 4'(6 + ($urandom % 10));
            if (sel == 0) begin
                stage[3:0] = 4'(1 + ($urandom % 5));
                run_bus(stage, 1'($urandom % 2), 1'b0);
            end else begin
                if (sel == 1) begin
                    wr(2'd1, stage);
                    wr(2'd0, $urandom | 32'h1000_0000);
                    rd(2'd0, v);
                    check(v == 0, "R3 random non-start word", v, 0);
                end
                run_plain(stage, "R5 R2 random");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule